// File: doc/BRIEF.md
# Wide Ternary Match Engine

This block holds a table of 272-bit ternary entries and searches the whole table for a 272-bit key. Each entry is stored as four 68-bit words at consecutive word addresses 4e+0 to 4e+3, called slots 0 to 3. A search picks two global mask pairs. The first pair masks the upper half of the key and the second pair masks the lower half. Each stored word also has its own local don't-care bits. All entries are compared in parallel. The lowest-numbered matching entry wins.

The result appears two clock cycles after the request. A hit gives a 24-bit SRAM address: the winning word address (always a multiple of four) sits in the low bits, and a two-bit tag from the request sits in bits [21:20]. The outcome is also written to one of eight result registers chosen by the request. That register can be read back through a combinational read port. Table words and mask words are loaded through simple single-cycle write ports.

Top module: `wide_tcam_search`

## Requirements
- R1: After reset, `res_valid`, `res_hit` and `res_miss` are 0, and every result register reads back with its hit flag 0 and address 0. All mask pairs and table words reset to zero.
- R2: The key is split into four beats, and each beat is compared with one slot of the entry:
  - key[271:204] with slot 0
  - key[203:136] with slot 1
  - key[135:68] with slot 2
  - key[67:0] with slot 3

  A key with its beats out of this order does not match.
- R3: Mask pair `srch_gsel_hi` masks key[271:136]: its half 0 applies to slot 0 and its half 1 to slot 1. Mask pair `srch_gsel_lo` masks key[135:0]: its half 0 applies to slot 2 and its half 1 to slot 3. A global mask bit of 1 makes that bit take part in the compare, and a 0 ignores it.
- R4: A local mask bit of 1 in a stored word makes that bit don't-care for that entry only. An entry matches only when every bit that is enabled by the global mask and not excluded by the local mask agrees.
- R5: When several entries match, the entry with the lowest index wins.
- R6: On a hit, `res_addr` is laid out as follows:
  - bits [19:0] hold the word address 4*winner, so the two LSBs are 00
  - bits [21:20] hold `srch_tag`
  - bits [23:22] are 0

  On a miss, `res_addr` is 0.
- R7: A request in cycle n gives `res_valid` high for exactly one cycle, in cycle n+2. In that cycle exactly one of `res_hit` and `res_miss` is high. Neither is high while `res_valid` is low. Back-to-back requests give back-to-back results.
- R8: The result register chosen by `srch_dst` is written together with the result. A hit stores hit flag 1 and the `res_addr` value. A miss stores hit flag 0 and address 0. The other result registers keep their contents.
- R9: A mask write (`mreg_we`) writes `mreg_data` only to half `mreg_half` of pair `mreg_idx`. The other half and the other pairs are unchanged.
- R10: A table write (`tbl_we`) stores the data word and the local mask word at word address `tbl_addr`. Address bits [1:0] select the slot and the upper bits select the entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tbl_we | input | 1 | Table word write strobe |
| tbl_addr | input | AW | Table word address (entry*4 + slot) |
| tbl_data | input | 68 | Stored data word |
| tbl_dcmask | input | 68 | Local mask word, 1 = don't care |
| mreg_we | input | 1 | Mask register write strobe |
| mreg_idx | input | MIW | Mask pair to write |
| mreg_half | input | 1 | Half of the pair to write (0 or 1) |
| mreg_data | input | 68 | Mask word, 1 = compare |
| srch_req | input | 1 | Search request |
| srch_key | input | 272 | Search key |
| srch_gsel_hi | input | MIW | Mask pair for key[271:136] |
| srch_gsel_lo | input | MIW | Mask pair for key[135:0] |
| srch_dst | input | SIW | Result register to update |
| srch_tag | input | 2 | Bits placed in res_addr[21:20] on hit |
| res_valid | output | 1 | Result strobe |
| res_hit | output | 1 | Search found a match |
| res_miss | output | 1 | Search found no match |
| res_addr | output | 24 | SRAM address of the winner |
| ssr_idx | input | SIW | Result register read select |
| ssr_hit | output | 1 | Hit flag of the selected result register |
| ssr_addr | output | 24 | Address held in the selected result register |

## Verification
The bench builds a table in which two entries are identical. This catches a priority encoder that picks the highest or the last match instead of the lowest. Single-byte corruptions are placed in each key beat in turn and then paired with mask pairs that hide only that byte. This exposes a swapped slot mapping, a swapped half within a pair, or a high/low pair selection that is mixed up: each of these turns a planned hit into a miss, or a planned miss into a hit. One entry carries a local don't-care byte, so an inverted local-mask polarity shows up as a miss. Reusing result registers after a hit shows whether a miss really clears the flag. A one-cycle latency error, or a table write that lands in the wrong slot, shows up in the directed tests.

// File: rtl/wtm_pkg.sv
package wtm_pkg;

   localparam int WORD_W = 68;
   localparam int SLOTS  = 4;
   localparam int KEY_W  = WORD_W * SLOTS;
   localparam int OUT_AW = 24;
   localparam int LOW_AW = 20;

   typedef logic [WORD_W-1:0] word_t;

   typedef struct packed {
      logic              hit;
      logic [OUT_AW-1:0] addr;
   } ssr_t;

   // one stored word agrees with its key beat under both masks
   function automatic logic word_agrees(word_t stored, word_t beat,
                                        word_t gmask, word_t dcmask);
      return ~|((stored ^ beat) & gmask & ~dcmask);
   endfunction

endpackage

// File: rtl/wtm_mask_bank.sv
module wtm_mask_bank
   import wtm_pkg::*;
#(
   parameter int NUM_PAIR = 8,
   localparam int IW = $clog2(NUM_PAIR)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IW-1:0]    wr_idx,
   input  logic             wr_half,
   input  word_t            wr_data,
   input  logic [IW-1:0]    sel_hi,
   input  logic [IW-1:0]    sel_lo,
   output word_t [SLOTS-1:0] slot_mask
);

   word_t pair_q [NUM_PAIR][2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int p = 0; p < NUM_PAIR; p++) begin
            pair_q[p][0] <= '0;
            pair_q[p][1] <= '0;
         end
      end else if (wr_en) begin
         pair_q[wr_idx][wr_half] <= wr_data;
      end
   end

   // slots 0/1 take the upper-half pair, slots 2/3 the lower-half pair
   always_comb begin
      slot_mask[0] = pair_q[sel_hi][0];
      slot_mask[1] = pair_q[sel_hi][1];
      slot_mask[2] = pair_q[sel_lo][0];
      slot_mask[3] = pair_q[sel_lo][1];
   end

endmodule

// File: rtl/wtm_entry_array.sv
module wtm_entry_array
   import wtm_pkg::*;
#(
   parameter int DEPTH = 32,
   localparam int AW = $clog2(DEPTH),
   localparam int NE = DEPTH / SLOTS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  word_t             wr_data,
   input  word_t             wr_dcmask,
   input  word_t [SLOTS-1:0] key_beat,
   input  word_t [SLOTS-1:0] slot_mask,
   output logic [NE-1:0]     entry_hit
);

   word_t data_q [DEPTH];
   word_t dcm_q  [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int w = 0; w < DEPTH; w++) begin
            data_q[w] <= '0;
            dcm_q[w]  <= '0;
         end
      end else if (wr_en && (int'(wr_addr) < DEPTH)) begin
         data_q[wr_addr] <= wr_data;
         dcm_q[wr_addr]  <= wr_dcmask;
      end
   end

   for (genvar e = 0; e < NE; e++) begin : g_entry
      logic [SLOTS-1:0] slot_ok;
      for (genvar s = 0; s < SLOTS; s++) begin : g_slot
         assign slot_ok[s] = word_agrees(data_q[e*SLOTS+s], key_beat[s],
                                         slot_mask[s], dcm_q[e*SLOTS+s]);
      end
      assign entry_hit[e] = &slot_ok;
   end

endmodule

// File: rtl/wtm_first_hit.sv
module wtm_first_hit #(
   parameter int N = 8,
   localparam int EW = $clog2(N)
) (
   input  logic [N-1:0]  hit_vec,
   output logic          found,
   output logic [EW-1:0] win_idx
);

   // scan from the top so the lowest set bit is written last
   always_comb begin
      found   = 1'b0;
      win_idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (hit_vec[i]) begin
            found   = 1'b1;
            win_idx = EW'(i);
         end
      end
   end

endmodule

// File: rtl/wide_tcam_search.sv
module wide_tcam_search
   import wtm_pkg::*;
#(
   parameter int DEPTH     = 32,
   parameter int NUM_MPAIR = 8,
   parameter int NUM_SSR   = 8,
   localparam int AW  = $clog2(DEPTH),
   localparam int MIW = $clog2(NUM_MPAIR),
   localparam int SIW = $clog2(NUM_SSR)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    tbl_we,
   input  logic [AW-1:0]           tbl_addr,
   input  logic [wtm_pkg::WORD_W-1:0] tbl_data,
   input  logic [wtm_pkg::WORD_W-1:0] tbl_dcmask,
   input  logic                    mreg_we,
   input  logic [MIW-1:0]          mreg_idx,
   input  logic                    mreg_half,
   input  logic [wtm_pkg::WORD_W-1:0] mreg_data,
   input  logic                    srch_req,
   input  logic [wtm_pkg::KEY_W-1:0]  srch_key,
   input  logic [MIW-1:0]          srch_gsel_hi,
   input  logic [MIW-1:0]          srch_gsel_lo,
   input  logic [SIW-1:0]          srch_dst,
   input  logic [1:0]              srch_tag,
   output logic                    res_valid,
   output logic                    res_hit,
   output logic                    res_miss,
   output logic [wtm_pkg::OUT_AW-1:0] res_addr,
   input  logic [SIW-1:0]          ssr_idx,
   output logic                    ssr_hit,
   output logic [wtm_pkg::OUT_AW-1:0] ssr_addr
);

   localparam int NE = DEPTH / SLOTS;
   localparam int EW = $clog2(NE);

   if ((DEPTH % SLOTS) != 0 || DEPTH < 2 * SLOTS || AW > LOW_AW) begin : g_bad_depth
      $error("DEPTH must be a multiple of 4, at least 8, and fit in 20 address bits");
   end
   if (NUM_MPAIR < 2 || (1 << MIW) != NUM_MPAIR) begin : g_bad_pairs
      $error("NUM_MPAIR must be a power of two of at least 2");
   end
   if (NUM_SSR < 2 || (1 << SIW) != NUM_SSR) begin : g_bad_ssr
      $error("NUM_SSR must be a power of two of at least 2");
   end

   // key beat 0 is the most significant 68 bits
   word_t [SLOTS-1:0] key_beat;
   for (genvar s = 0; s < SLOTS; s++) begin : g_beat
      assign key_beat[s] = srch_key[KEY_W-1-s*WORD_W -: WORD_W];
   end

   word_t [SLOTS-1:0] slot_mask;
   logic  [NE-1:0]    entry_hit;

   wtm_mask_bank #(.NUM_PAIR(NUM_MPAIR)) u_masks (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (mreg_we),
      .wr_idx    (mreg_idx),
      .wr_half   (mreg_half),
      .wr_data   (mreg_data),
      .sel_hi    (srch_gsel_hi),
      .sel_lo    (srch_gsel_lo),
      .slot_mask (slot_mask)
   );

   wtm_entry_array #(.DEPTH(DEPTH)) u_table (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (tbl_we),
      .wr_addr   (tbl_addr),
      .wr_data   (tbl_data),
      .wr_dcmask (tbl_dcmask),
      .key_beat  (key_beat),
      .slot_mask (slot_mask),
      .entry_hit (entry_hit)
   );

   // stage 1: registered compare vector and request context
   logic            s1_valid;
   logic [NE-1:0]   s1_hits;
   logic [SIW-1:0]  s1_dst;
   logic [1:0]      s1_tag;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_hits  <= '0;
         s1_dst   <= '0;
         s1_tag   <= '0;
      end else begin
         s1_valid <= srch_req;
         s1_hits  <= entry_hit;
         s1_dst   <= srch_dst;
         s1_tag   <= srch_tag;
      end
   end

   logic          win_found;
   logic [EW-1:0] win_idx;

   wtm_first_hit #(.N(NE)) u_prio (
      .hit_vec (s1_hits),
      .found   (win_found),
      .win_idx (win_idx)
   );

   logic [LOW_AW-1:0] win_word;
   logic [OUT_AW-1:0] win_addr;

   always_comb begin
      win_word           = '0;
      win_word[AW-1:0]   = {win_idx, 2'b00};
      win_addr           = {2'b00, s1_tag, win_word};
   end

   // stage 2: result strobe and result register file
   ssr_t ssr_q [NUM_SSR];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_hit   <= 1'b0;
         res_miss  <= 1'b0;
         res_addr  <= '0;
         for (int r = 0; r < NUM_SSR; r++) ssr_q[r] <= '0;
      end else begin
         res_valid <= s1_valid;
         res_hit   <= s1_valid & win_found;
         res_miss  <= s1_valid & ~win_found;
         res_addr  <= (s1_valid && win_found) ? win_addr : '0;
         if (s1_valid) begin
            ssr_q[s1_dst].hit  <= win_found;
            ssr_q[s1_dst].addr <= win_found ? win_addr : '0;
         end
      end
   end

   assign ssr_hit  = ssr_q[ssr_idx].hit;
   assign ssr_addr = ssr_q[ssr_idx].addr;

endmodule

// File: rtl/wide_tcam_search_chk.sv
module wide_tcam_search_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        srch_req,
   input logic        res_valid,
   input logic        res_hit,
   input logic        res_miss,
   input logic [23:0] res_addr
);

   // R7
   lat_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
      srch_req |=> ##1 res_valid);

   // R7
   one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (res_hit ^ res_miss));

   // R7
   quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |-> (!res_hit && !res_miss));

   // R6
   hit_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_hit |-> (res_addr[1:0] == 2'b00 && res_addr[23:22] == 2'b00));

   // R6
   miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_miss |-> (res_addr == 24'd0));

endmodule

bind wide_tcam_search wide_tcam_search_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .srch_req  (srch_req),
   .res_valid (res_valid),
   .res_hit   (res_hit),
   .res_miss  (res_miss),
   .res_addr  (res_addr)
);

// File: tb/wide_tcam_search_test.sv
`timescale 1ns/1ps
module wide_tcam_search_test;

   localparam int DEPTH = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         tbl_we = 1'b0;
   logic [4:0]   tbl_addr = '0;
   logic [67:0]  tbl_data = '0;
   logic [67:0]  tbl_dcmask = '0;
   logic         mreg_we = 1'b0;
   logic [2:0]   mreg_idx = '0;
   logic         mreg_half = 1'b0;
   logic [67:0]  mreg_data = '0;
   logic         srch_req = 1'b0;
   logic [271:0] srch_key = '0;
   logic [2:0]   srch_gsel_hi = '0;
   logic [2:0]   srch_gsel_lo = '0;
   logic [2:0]   srch_dst = '0;
   logic [1:0]   srch_tag = '0;
   logic         res_valid, res_hit, res_miss;
   logic [23:0]  res_addr;
   logic [2:0]   ssr_idx = '0;
   logic         ssr_hit;
   logic [23:0]  ssr_addr;

   always #2.5 clk = ~clk;

   wide_tcam_search #(.DEPTH(DEPTH)) uut (
      .clk(clk), .rst_n(rst_n),
      .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_data(tbl_data), .tbl_dcmask(tbl_dcmask),
      .mreg_we(mreg_we), .mreg_idx(mreg_idx), .mreg_half(mreg_half), .mreg_data(mreg_data),
      .srch_req(srch_req), .srch_key(srch_key), .srch_gsel_hi(srch_gsel_hi),
      .srch_gsel_lo(srch_gsel_lo), .srch_dst(srch_dst), .srch_tag(srch_tag),
      .res_valid(res_valid), .res_hit(res_hit), .res_miss(res_miss), .res_addr(res_addr),
      .ssr_idx(ssr_idx), .ssr_hit(ssr_hit), .ssr_addr(ssr_addr)
   );

   int checks = 0;
   int fails  = 0;

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [67:0] pat(int e, int s);
      return {8'(16 * e + s), {15{4'h6}}};
   endfunction

   // c: 0..3 corrupt top byte of that beat, 4 none, 5 swap beats 0 and 1
   function automatic logic [271:0] mk_key(int b, int c);
      logic [67:0] w [4];
      logic [67:0] t;
      for (int s = 0; s < 4; s++) w[s] = pat(b, s);
      if (c < 4) w[c][67:60] = 8'hFF;
      if (c == 5) begin t = w[0]; w[0] = w[1]; w[1] = t; end
      return {w[0], w[1], w[2], w[3]};
   endfunction

   function automatic logic [23:0] exp_addr(logic hit, logic [1:0] tag, int ent);
      return hit ? {2'b00, tag, 20'(ent * 4)} : 24'd0;
   endfunction

   task automatic wr_word(int a, logic [67:0] d, logic [67:0] m);
      @(negedge clk);
      tbl_we = 1'b1; tbl_addr = 5'(a); tbl_data = d; tbl_dcmask = m;
      @(negedge clk);
      tbl_we = 1'b0;
   endtask

   task automatic wr_mask(int p, logic h, logic [67:0] d);
      @(negedge clk);
      mreg_we = 1'b1; mreg_idx = 3'(p); mreg_half = h; mreg_data = d;
      @(negedge clk);
      mreg_we = 1'b0;
   endtask

   // drive at a falling edge, sample two rising edges later
   task automatic search(logic [271:0] k, int hi, int lo, int dst, logic [1:0] tag);
      @(negedge clk);
      srch_req = 1'b1; srch_key = k; srch_gsel_hi = 3'(hi);
      srch_gsel_lo = 3'(lo); srch_dst = 3'(dst); srch_tag = tag;
      @(negedge clk);
      srch_req = 1'b0;
      @(negedge clk);
   endtask

   task automatic chk_result(string req, logic hit, logic [1:0] tag, int ent, int dst);
      chk(req, "res_valid", 32'(res_valid), 32'd1);
      chk(req, "res_hit", 32'(res_hit), 32'(hit));
      chk(req, "res_miss", 32'(res_miss), 32'(!hit));
      chk(req, "res_addr", 32'(res_addr), 32'(exp_addr(hit, tag, ent)));
      ssr_idx = 3'(dst);
      #0.1;
      chk(req, "ssr_hit", 32'(ssr_hit), 32'(hit));
      chk(req, "ssr_addr", 32'(ssr_addr), 32'(exp_addr(hit, tag, ent)));
   endtask

   typedef struct packed {
      logic [3:0] b;
      logic [3:0] c;
      logic [2:0] hi;
      logic [2:0] lo;
      logic [2:0] dst;
      logic [1:0] tag;
      logic       hit;
      logic [3:0] ent;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      '{b:2, c:4, hi:0, lo:0, dst:0, tag:1, hit:1, ent:2},
      '{b:3, c:4, hi:0, lo:0, dst:1, tag:2, hit:1, ent:3},
      '{b:4, c:0, hi:0, lo:0, dst:2, tag:3, hit:0, ent:0},
      '{b:4, c:0, hi:1, lo:0, dst:2, tag:0, hit:1, ent:4},
      '{b:4, c:3, hi:1, lo:0, dst:3, tag:1, hit:0, ent:0},
      '{b:4, c:3, hi:0, lo:3, dst:3, tag:2, hit:1, ent:4},
      '{b:1, c:0, hi:2, lo:0, dst:4, tag:3, hit:1, ent:1},
      '{b:1, c:0, hi:2, lo:2, dst:5, tag:1, hit:1, ent:0},
      '{b:5, c:2, hi:0, lo:0, dst:6, tag:2, hit:1, ent:5},
      '{b:2, c:2, hi:0, lo:0, dst:7, tag:3, hit:0, ent:0},
      '{b:2, c:5, hi:0, lo:0, dst:0, tag:0, hit:0, ent:0},
      '{b:4, c:2, hi:0, lo:3, dst:1, tag:1, hit:0, ent:0}
   };
   localparam string VREQ [NV] = '{"R2", "R5", "R3", "R3", "R3", "R3",
                                   "R3", "R5", "R4", "R4", "R2", "R9"};

   initial begin
      logic [67:0] ones;
      logic [67:0] newb;
      ones = '1;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", "res_valid", 32'(res_valid), 32'd0);
      chk("R1", "res_hit", 32'(res_hit), 32'd0);
      chk("R1", "res_miss", 32'(res_miss), 32'd0);
      for (int r = 0; r < 8; r++) begin
         ssr_idx = 3'(r);
         #0.1;
         chk("R1", "ssr_hit", 32'(ssr_hit), 32'd0);
      end
      rst_n = 1'b1;

      // table: entry 6 duplicates entry 3, entry 5 slot 2 has a don't-care top byte
      for (int e = 0; e < 8; e++) begin
         for (int s = 0; s < 4; s++) begin
            wr_word(e * 4 + s, pat((e == 6) ? 3 : e, s),
                    (e == 5 && s == 2) ? {8'hFF, 60'd0} : 68'd0);
         end
      end
      // mask pairs: 0 full, 1 hides beat-0 top byte, 2 empty, 3 hides beat-3 top byte
      wr_mask(0, 1'b0, ones);               wr_mask(0, 1'b1, ones);
      wr_mask(1, 1'b0, {8'h00, ones[59:0]}); wr_mask(1, 1'b1, ones);
      wr_mask(3, 1'b0, ones);               wr_mask(3, 1'b1, {8'h00, ones[59:0]});

      for (int v = 0; v < NV; v++) begin
         search(mk_key(int'(VECS[v].b), int'(VECS[v].c)), int'(VECS[v].hi),
                int'(VECS[v].lo), int'(VECS[v].dst), VECS[v].tag);
         chk_result(VREQ[v], VECS[v].hit, VECS[v].tag, int'(VECS[v].ent), int'(VECS[v].dst));
      end

      // R8: register 6 untouched by later searches to other registers
      ssr_idx = 3'd6;
      #0.1;
      chk("R8", "ssr6_hit", 32'(ssr_hit), 32'd1);
      chk("R8", "ssr6_addr", 32'(ssr_addr), 32'(exp_addr(1'b1, 2'd2, 5)));

      // R8: hit then miss into the same register clears the flag
      search(mk_key(7, 4), 0, 0, 5, 2'd3);
      chk_result("R8", 1'b1, 2'd3, 7, 5);
      search(mk_key(7, 0), 0, 0, 5, 2'd3);
      chk_result("R8", 1'b0, 2'd0, 0, 5);

      // R7: latency and single-cycle strobe
      @(negedge clk);
      srch_req = 1'b1; srch_key = mk_key(2, 4); srch_gsel_hi = 3'd0;
      srch_gsel_lo = 3'd0; srch_dst = 3'd4; srch_tag = 2'd0;
      @(negedge clk);
      srch_req = 1'b0;
      chk("R7", "valid_at_1", 32'(res_valid), 32'd0);
      @(negedge clk);
      chk("R7", "valid_at_2", 32'(res_valid), 32'd1);
      @(negedge clk);
      chk("R7", "valid_at_3", 32'(res_valid), 32'd0);

      // R7: back-to-back requests
      @(negedge clk);
      srch_req = 1'b1; srch_key = mk_key(2, 4); srch_tag = 2'd1;
      @(negedge clk);
      srch_key = mk_key(3, 4); srch_tag = 2'd2;
      @(negedge clk);
      srch_req = 1'b0;
      chk("R7", "b2b_first", 32'(res_addr), 32'(exp_addr(1'b1, 2'd1, 2)));
      @(negedge clk);
      chk("R7", "b2b_second", 32'(res_addr), 32'(exp_addr(1'b1, 2'd2, 3)));
      chk("R7", "b2b_valid", 32'(res_valid), 32'd1);

      // R10: rewrite slot 1 of entry 7 at word address 29
      newb = pat(7, 1) ^ 68'h1;
      wr_word(29, newb, 68'd0);
      search(mk_key(7, 4), 0, 0, 2, 2'd1);
      chk_result("R10", 1'b0, 2'd0, 0, 2);
      search({pat(7, 0), newb, pat(7, 2), pat(7, 3)}, 0, 0, 2, 2'd1);
      chk_result("R10", 1'b1, 2'd1, 7, 2);

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule